// File: doc/BRIEF.md
# Link Receive Sequence and Integrity Checker

This block sits on the receive side of a point-to-point link, between the framing logic and the transaction layer. Each framed packet arrives one byte per cycle with start and end markers. The block checks the packet's 32-bit CRC and compares its sequence number with the one it expects. Packets that pass both checks go to the upper layer and produce an acknowledge request carrying their sequence number. Packets that fail are dropped, and one negative-acknowledge request names the sequence number from which the sender must retransmit.

After a failure the block stays in an error episode. Every later packet is discarded without a further NAK until a packet carrying the expected sequence number arrives intact. The payload is held in a staging buffer the size of one packet. The payload becomes visible to the upper layer only after the trailing CRC has been checked.

Frame layout, in byte order:
- Byte 0: reserved upper bits, then the high bits of the sequence number.
- Byte 1: the low eight bits of the sequence number.
- Zero to MAX_PAY payload bytes.
- Four CRC bytes, least significant byte first.

The CRC is the reflected CRC-32 (polynomial 0xEDB88320, initial value all ones, final inversion). It covers the header and payload bytes.

Top module: `rx_seq_guard`

## Requirements
- R1: While reset is asserted, and after it is released, out_valid, ack_valid and nak_valid are low and the expected sequence number is 0.
- R2: A good packet appears on out_valid for exactly one cycle, one clock after its end byte is taken. It presents payload byte k on out_data[8k+7:8k], the payload length on out_len and the sequence number on out_seq.
- R3: A good packet raises ack_valid for one cycle together with out_valid, with ackn_seq equal to the packet's sequence number. The expected sequence number then advances by one.
- R4: A packet whose received CRC differs from the CRC computed over its header and payload is dropped: no out_valid and no ack_valid.
- R5: A packet whose sequence number differs from the expected value is dropped, even when its CRC is correct.
- R6: The first invalid packet after a good one, or after reset, raises nak_valid for one cycle one clock after its end byte, with ackn_seq equal to the expected sequence number.
- R7: While in an error episode, every further packet that is not an intact packet with the expected sequence number is dropped and raises no NAK.
- R8: An intact packet with the expected sequence number ends the error episode and is accepted. A later invalid packet raises a new NAK.
- R9: Sequence numbers are 12 bits and wrap from 4095 to 0.
- R10: A frame shorter than six bytes, or one whose payload exceeds MAX_PAY bytes, is invalid. A payload of exactly MAX_PAY bytes is accepted.
- R11: ack_valid and nak_valid are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A frame byte is present |
| in_sop | input | 1 | Byte is the first of a frame |
| in_eop | input | 1 | Byte is the last of a frame |
| in_data | input | 8 | Frame byte |
| out_valid | output | 1 | One-cycle pulse: accepted packet on the outputs |
| out_seq | output | SEQ_W | Sequence number of the accepted packet |
| out_len | output | LEN_W | Payload length in bytes |
| out_data | output | MAX_PAY*8 | Payload, byte k in bits 8k+7:8k |
| ack_valid | output | 1 | One-cycle acknowledge request |
| nak_valid | output | 1 | One-cycle negative-acknowledge request |
| ackn_seq | output | SEQ_W | Sequence number for the ACK or NAK request |

## Verification
Every result of this block (forwarding, ACK or NAK) is registered on the clock edge that takes a frame's end byte. Each result is therefore due in the cycle that follows, and it lasts one cycle. The bench drives bytes after a falling edge and compares all outputs at the next falling edge against a behavioural model. The model is updated when the end byte is driven, so each comparison falls in exactly the cycle the result belongs to. Every other cycle is checked as idle, which catches extra or late pulses.

// File: rtl/rx_seq_guard.sv
module rx_seq_guard #(
  parameter int SEQ_W   = 12,
  parameter int MAX_PAY = 16,
  localparam int LEN_W  = $clog2(MAX_PAY + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic                   in_sop,
  input  logic                   in_eop,
  input  logic [7:0]             in_data,
  output logic                   out_valid,
  output logic [SEQ_W-1:0]       out_seq,
  output logic [LEN_W-1:0]       out_len,
  output logic [MAX_PAY*8-1:0]   out_data,
  output logic                   ack_valid,
  output logic                   nak_valid,
  output logic [SEQ_W-1:0]       ackn_seq
);
  localparam int IDX_W = $clog2(MAX_PAY + 7) + 1;
  localparam logic [31:0] POLY = 32'hEDB88320;

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int k = 0; k < 8; k++)
      r = (r[0] ^ d[k]) ? ((r >> 1) ^ POLY) : (r >> 1);
    return r;
  endfunction

  logic              in_pkt, over, err;
  logic [IDX_W-1:0]  idx;
  logic [31:0]       win, crc;
  logic [SEQ_W-9:0]  seq_hi;
  logic [7:0]        seq_lo;
  logic [SEQ_W-1:0]  exp_seq;
  logic [7:0]        pbuf [MAX_PAY];

  logic              take, fin, over_nx, len_ok, crc_ok, good, wr_en;
  logic [IDX_W-1:0]  cur_idx, pay_idx;
  logic [31:0]       crc_cur, crc_nx;

  assign take    = in_valid && (in_sop || in_pkt);
  assign fin     = take && in_eop;
  assign cur_idx = in_sop ? '0 : idx;
  assign crc_cur = in_sop ? '1 : crc;
  assign crc_nx  = (cur_idx >= IDX_W'(4)) ? crc_step(crc_cur, win[31:24]) : crc_cur;
  assign over_nx = (!in_sop && over) || (cur_idx >= IDX_W'(MAX_PAY + 6));
  assign pay_idx = cur_idx - IDX_W'(6);
  assign wr_en   = take && (cur_idx >= IDX_W'(6)) && !over_nx;
  assign len_ok  = (cur_idx >= IDX_W'(5)) && !over_nx;
  assign crc_ok  = (crc_nx ^ 32'hFFFFFFFF) == {in_data, win[7:0], win[15:8], win[23:16]};
  assign good    = crc_ok && len_ok && ({seq_hi, seq_lo} == exp_seq);

  for (genvar g = 0; g < MAX_PAY; g++) begin : g_buf
    always_ff @(posedge clk)
      if (wr_en && pay_idx == IDX_W'(g)) pbuf[g] <= win[31:24];
    assign out_data[g*8 +: 8] = pbuf[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_pkt <= 1'b0;
      over   <= 1'b0;
      idx    <= '0;
      win    <= '0;
      crc    <= '1;
      seq_hi <= '0;
      seq_lo <= '0;
    end else if (take) begin
      in_pkt <= !in_eop;
      over   <= over_nx;
      idx    <= over_nx ? cur_idx : cur_idx + IDX_W'(1);
      win    <= {win[23:0], in_data};
      crc    <= crc_nx;
      if (cur_idx == IDX_W'(0)) seq_hi <= in_data[SEQ_W-9:0];
      if (cur_idx == IDX_W'(1)) seq_lo <= in_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_seq   <= '0;
      err       <= 1'b0;
      out_valid <= 1'b0;
      ack_valid <= 1'b0;
      nak_valid <= 1'b0;
      out_seq   <= '0;
      out_len   <= '0;
      ackn_seq  <= '0;
    end else begin
      out_valid <= fin && good;
      ack_valid <= fin && good;
      nak_valid <= fin && !good && !err;
      if (fin) begin
        if (good || !err) ackn_seq <= exp_seq;
        if (good) begin
          exp_seq <= exp_seq + SEQ_W'(1);
          err     <= 1'b0;
          out_seq <= exp_seq;
          out_len <= LEN_W'(cur_idx - IDX_W'(5));
        end else begin
          err <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rx_seq_guard_chk.sv
module rx_seq_guard_chk #(
  parameter int SEQ_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_eop,
  input logic             out_valid,
  input logic [SEQ_W-1:0] out_seq,
  input logic             ack_valid,
  input logic             nak_valid,
  input logic [SEQ_W-1:0] ackn_seq
);
  logic [SEQ_W-1:0] exp_c;
  logic             nak_open;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_c    <= '0;
      nak_open <= 1'b0;
    end else begin
      if (ack_valid) exp_c <= exp_c + SEQ_W'(1);
      if (ack_valid) nak_open <= 1'b0;
      else if (nak_valid) nak_open <= 1'b1;
    end
  end

  assert_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ack_valid, nak_valid}));

  assert_ack_fwd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |-> (out_valid && out_seq == ackn_seq));

  assert_after_eop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid || nak_valid) |-> $past(in_valid && in_eop));

  assert_ack_order_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |-> ackn_seq == exp_c);

  assert_nak_seq_R6: assert property (@(posedge clk) disable iff (!rst_n)
    nak_valid |-> ackn_seq == exp_c);

  assert_single_nak_R7: assert property (@(posedge clk) disable iff (!rst_n)
    nak_valid |-> !nak_open);
endmodule

bind rx_seq_guard rx_seq_guard_chk #(.SEQ_W(SEQ_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_eop(in_eop),
  .out_valid(out_valid), .out_seq(out_seq), .ack_valid(ack_valid),
  .nak_valid(nak_valid), .ackn_seq(ackn_seq)
);

// File: tb/rx_seq_guard_tb.sv
`timescale 1ns/1ps
module rx_seq_guard_tb;
  localparam int SEQ_W = 12, MAX_PAY = 16, LEN_W = $clog2(MAX_PAY + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
  logic [7:0] in_data = '0;
  logic out_valid, ack_valid, nak_valid;
  logic [SEQ_W-1:0] out_seq, ackn_seq;
  logic [LEN_W-1:0] out_len;
  logic [MAX_PAY*8-1:0] out_data;

  rx_seq_guard #(.SEQ_W(SEQ_W), .MAX_PAY(MAX_PAY)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
    .in_eop(in_eop), .in_data(in_data), .out_valid(out_valid),
    .out_seq(out_seq), .out_len(out_len), .out_data(out_data),
    .ack_valid(ack_valid), .nak_valid(nak_valid), .ackn_seq(ackn_seq));

  always #2 clk = ~clk;

  int checks = 0, fails = 0;
  string cur_req = "R1";
  int m_exp = 0;
  bit m_err = 0;
  bit e_ov = 0, e_ack = 0, e_nak = 0;
  int e_seq = 0, e_len = 0;
  logic [7:0] e_pay [MAX_PAY];

  function automatic logic [31:0] ref_crc(input logic [7:0] fr[$]);
    logic [31:0] c = 32'hFFFFFFFF;
    foreach (fr[i]) begin
      c = c ^ {24'h0, fr[i]};
      for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return ~c;
  endfunction

  task automatic tick();
    bit bad = 0;
    @(negedge clk);
    checks++;
    if (out_valid !== e_ov || ack_valid !== e_ack || nak_valid !== e_nak) bad = 1;
    if ((e_ack || e_nak) && ackn_seq !== 12'(e_seq)) bad = 1;
    if (e_ov) begin
      if (out_seq !== 12'(e_seq) || out_len !== LEN_W'(e_len)) bad = 1;
      for (int k = 0; k < e_len; k++)
        if (out_data[k*8 +: 8] !== e_pay[k]) bad = 1;
    end
    if (bad) begin
      fails++;
      $display("FAIL %s: got ov=%0b ack=%0b nak=%0b seq=%0d oseq=%0d len=%0d, expected ov=%0b ack=%0b nak=%0b seq=%0d len=%0d",
               cur_req, out_valid, ack_valid, nak_valid, ackn_seq, out_seq, out_len,
               e_ov, e_ack, e_nak, e_seq, e_len);
    end
    e_ov = 0; e_ack = 0; e_nak = 0;
  endtask

  task automatic model(input int seq, input bit intact, input logic [7:0] fr[$]);
    int pl = fr.size() - 6;
    if (intact && fr.size() >= 6 && pl <= MAX_PAY && (seq % 4096) == m_exp) begin
      e_ov = 1; e_ack = 1; e_seq = m_exp; e_len = pl;
      for (int k = 0; k < pl; k++) e_pay[k] = fr[2 + k];
      m_exp = (m_exp + 1) % 4096;
      m_err = 0;
    end else if (!m_err) begin
      e_nak = 1; e_seq = m_exp; m_err = 1;
    end
  endtask

  task automatic send(input int seq, input int plen, input bit corrupt = 0, input int cut = 0);
    logic [7:0] fr[$];
    logic [31:0] c;
    fr.push_back(8'((seq >> 8) & 15));
    fr.push_back(8'(seq & 255));
    for (int k = 0; k < plen; k++) fr.push_back(8'(seq * 7 + k * 13 + 1));
    c = ref_crc(fr);
    fr.push_back(c[7:0]); fr.push_back(c[15:8]);
    fr.push_back(c[23:16]); fr.push_back(c[31:24]);
    if (corrupt) fr[fr.size() - 2] = fr[fr.size() - 2] ^ 8'h5A;
    if (cut > 0) while (fr.size() > cut) void'(fr.pop_back());
    for (int i = 0; i < fr.size(); i++) begin
      tick();
      in_valid = 1; in_sop = (i == 0); in_eop = (i == fr.size() - 1); in_data = fr[i];
      if (in_eop) model(seq, !corrupt && cut == 0, fr);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      tick();
      in_valid = 0; in_sop = 0; in_eop = 0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got no end, expected finish before 200000 cycles");
    $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
    $finish;
  end

  initial begin
    cur_req = "R1";
    repeat (3) @(posedge clk);
    tick();
    rst_n = 1;
    idle(2);
    cur_req = "R2";
    send(0, 5); idle(1);
    cur_req = "R3";
    send(1, 0); send(2, 16); idle(2);
    cur_req = "R4,R6";
    send(3, 4, 1); idle(1);
    cur_req = "R7";
    send(4, 3); idle(1);
    send(3, 2, 1); idle(1);
    send(5, 1); idle(1);
    cur_req = "R8";
    send(3, 6); idle(1);
    send(4, 2); idle(1);
    send(4, 2); idle(1);
    send(5, 1); idle(1);
    cur_req = "R5";
    send(7, 2); idle(1);
    send(6, 3); idle(1);
    cur_req = "R10";
    send(7, 3, 0, 4); idle(1);
    send(7, 3); idle(1);
    send(8, 17); idle(1);
    send(8, 16); idle(1);
    cur_req = "R9";
    for (int s = 9; s < 4096; s++) send(s, 0);
    idle(1);
    send(0, 2); idle(1);
    send(1, 1); idle(2);
    cur_req = "R11";
    send(1, 1); send(2, 1, 1); send(2, 3); idle(2);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule